// File: doc/BRIEF.md
# Fan tachometer speed monitor

The block measures how fast a fan turns by timing the interval between successive rising edges of its tachometer pulse. A prescaled tick derived from the system clock is counted across each interval, so the measured count grows as the fan slows down. With two tachometer pulses per revolution, one interval is half a revolution. Converting the count to a rotation speed is left to software.

Each finished interval loads a 12-bit speed register in one step and marks the new value with a one-cycle valid pulse. The count saturates at 4095 and does not wrap, so a stopped or very slow fan reads as the maximum. A sticky alarm is raised in two cases: a finished interval whose count is above a programmable limit, or an interval count that has reached saturation, which means the fan is too slow to measure. A clear strobe resets the alarm. If the alarm condition is still present, the alarm sets again.

Top module: `fan_tach_monitor`

## Requirements
- R1: While reset is active, and after it is released, `speed_o` is 0, `speed_valid_o` is 0 and `alarm_o` is 0.
- R2: `tach_i` passes through a two-stage synchronizer and only its rising edges are used. A rising edge of `tach_i` set up before clock edge k causes its effect on the outputs just after clock edge k+2.
- R3: One reference tick occurs every PRESCALE clocks (default 4). A rising edge restarts both the tick phase and the count. For two rising edges P clocks apart, the published count is floor((P-1)/PRESCALE).
- R4: The interval count saturates at 4095 and never wraps. An interval longer than 4095 ticks publishes 4095.
- R5: `speed_o` changes only in the cycle in which `speed_valid_o` is high, and `speed_valid_o` is never high in two consecutive cycles. The first rising edge after reset only starts a measurement and publishes nothing.
- R6: The alarm sets when a published count is strictly greater than `limit_i`. A count equal to the limit does not set it.
- R7: The alarm sets once the running interval count reaches 4095, even when no further tachometer edge arrives.
- R8: The alarm stays set until `alarm_clr_i` is high for a clock edge. If a set condition is present in that same cycle, the alarm stays set. A saturated count therefore keeps the alarm set through a clear.
- R9: Falling edges of `tach_i`, and therefore the pulse's high time, have no effect on the measured count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; also the source of the reference tick |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tach_i | input | 1 | Tachometer pulse from the fan, asynchronous |
| limit_i | input | 12 | Low-speed limit, expressed as a maximum allowed count |
| alarm_clr_i | input | 1 | One-cycle strobe that clears the sticky alarm |
| speed_o | output | 12 | Most recent interval count |
| speed_valid_o | output | 1 | High for one cycle when `speed_o` is updated |
| alarm_o | output | 1 | Sticky low-speed or stalled-fan alarm |

## Verification
The hardest state to reach is saturation of the running count while the alarm is being cleared. It needs an interval more than 16,380 clocks long, a clear strobe that arrives after saturation, and then a fresh edge that publishes 4095. The stimulus holds the tachometer low for 20,000 clocks and pulses the clear partway through. The limit is raised beforehand so that only the stall can hold the alarm. A later clear, applied after the pulses have resumed, must take effect. The first-edge rule, the equal-to-limit boundary and pulses of different high times are driven as short pulse trains. A behavioural model in the bench is compared against all three outputs on every clock.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;
  localparam int unsigned DEF_CNT_W    = 12;
  localparam int unsigned DEF_PRESCALE = 4;
  localparam int unsigned DEF_SYNC     = 2;

  function automatic int unsigned pre_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fan_tach_sync.sv
module fan_tach_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tach_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= tach_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  p_rise_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/fan_tach_period.sv
module fan_tach_period #(
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned PRESCALE = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  output logic [CNT_W-1:0] speed_o,
  output logic             valid_o,
  output logic             pub_o,
  output logic [CNT_W-1:0] pub_cnt_o,
  output logic             stall_o
);
  localparam int unsigned      PRE_W    = fan_tach_pkg::pre_width(PRESCALE);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q, speed_q;
  logic             armed_q, valid_q, tick;

  assign tick = (pre_q == PRE_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (rise_i) begin
      pre_q   <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  // publish the finished interval in one step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      speed_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rise_i & armed_q;
      if (rise_i && armed_q) speed_q <= cnt_q;
    end
  end

  assign speed_o   = speed_q;
  assign valid_o   = valid_q;
  assign pub_o     = rise_i & armed_q;
  assign pub_cnt_o = cnt_q;
  assign stall_o   = (cnt_q == CNT_MAX);

  p_no_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !rise_i) |=> cnt_q == CNT_MAX);
  p_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> cnt_q == '0);
  p_valid_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> $stable(speed_q));
endmodule

// File: rtl/fan_tach_alarm.sv
module fan_tach_alarm #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pub_i,
  input  logic [CNT_W-1:0] pub_cnt_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             stall_i,
  input  logic             clr_i,
  output logic             alarm_o
);
  logic alarm_q, set;

  assign set = stall_i | (pub_i & (pub_cnt_i > limit_i));

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) alarm_q <= 1'b0;
    else         alarm_q <= set | (alarm_q & ~clr_i);

  assign alarm_o = alarm_q;

  p_over_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pub_i && pub_cnt_i > limit_i) |=> alarm_o);
  p_stall_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> alarm_o);
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_o && !clr_i) |=> alarm_o);
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !stall_i && !pub_i) |=> !alarm_o);
endmodule

// File: rtl/fan_tach_monitor.sv
module fan_tach_monitor #(
  parameter int unsigned CNT_W    = fan_tach_pkg::DEF_CNT_W,
  parameter int unsigned PRESCALE = fan_tach_pkg::DEF_PRESCALE,
  parameter int unsigned SYNC     = fan_tach_pkg::DEF_SYNC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tach_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             alarm_clr_i,
  output logic [CNT_W-1:0] speed_o,
  output logic             speed_valid_o,
  output logic             alarm_o
);
  logic             rise, pub, stall;
  logic [CNT_W-1:0] pub_cnt;

  fan_tach_sync #(.STAGES(SYNC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tach_i(tach_i),
    .rise_o(rise)
  );

  fan_tach_period #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_period (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (rise),
    .speed_o  (speed_o),
    .valid_o  (speed_valid_o),
    .pub_o    (pub),
    .pub_cnt_o(pub_cnt),
    .stall_o  (stall)
  );

  fan_tach_alarm #(.CNT_W(CNT_W)) u_alarm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pub_i    (pub),
    .pub_cnt_i(pub_cnt),
    .limit_i  (limit_i),
    .stall_i  (stall),
    .clr_i    (alarm_clr_i),
    .alarm_o  (alarm_o)
  );

  p_valid_speed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    speed_valid_o |-> $past(rise));
endmodule

// File: tb/fan_tach_monitor_test.sv
module fan_tach_monitor_test;
  localparam int PS = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tach = 1'b0;
  logic [11:0] limit = 12'd10;
  logic        clr = 1'b0;
  logic [11:0] speed;
  logic        valid, alarm;

  int n_checks = 0, n_fail = 0, valid_seen = 0;

  always #2.5 clk = ~clk;

  fan_tach_monitor uut (
    .clk_i(clk), .rst_ni(rst_ni), .tach_i(tach), .limit_i(limit),
    .alarm_clr_i(clr), .speed_o(speed), .speed_valid_o(valid), .alarm_o(alarm)
  );

  // behavioural reference
  int m_s1, m_s2, m_prev, m_pre, m_cnt, m_speed, m_valid, m_alarm, m_armed;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_pre = 0; m_cnt = 0;
      m_speed = 0; m_valid = 0; m_alarm = 0; m_armed = 0;
    end else begin
      int rise, setc;
      rise = (m_s2 == 1 && m_prev == 0) ? 1 : 0;
      setc = (m_cnt == 4095 || (rise == 1 && m_armed == 1 && m_cnt > int'(limit))) ? 1 : 0;
      if (setc == 1) m_alarm = 1;
      else if (clr) m_alarm = 0;
      m_valid = 0;
      if (rise == 1) begin
        if (m_armed == 1) begin m_speed = m_cnt; m_valid = 1; end
        m_armed = 1; m_cnt = 0; m_pre = 0;
      end else if (m_pre == PS - 1) begin
        m_pre = 0;
        if (m_cnt < 4095) m_cnt++;
      end else m_pre++;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = int'(tach);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni) begin
      check("R3 R4 speed vs model", int'(speed), m_speed);
      check("R5 valid vs model", int'(valid), m_valid);
      check("R6 R7 R8 alarm vs model", int'(alarm), m_alarm);
      if (valid) valid_seen++;
    end
  end

  // p clocks between rises, tach high for h clocks; check published value at i==4
  task automatic pulse_chk(input int p, input int h, input int exp, input int clr_at,
                           input string req);
    for (int i = 0; i < p; i++) begin
      @(negedge clk);
      if (i == 4 && exp >= 0) check(req, int'(speed), exp);
      tach = (i < h);
      clr  = (i == clr_at);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 speed in reset", int'(speed), 0);
    check("R1 valid in reset", int'(valid), 0);
    check("R1 alarm in reset", int'(alarm), 0);
    @(negedge clk) rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 speed after reset", int'(speed), 0);
    check("R1 alarm after reset", int'(alarm), 0);

    pulse_chk(41, 5, -1, -1, "");
    check("R5 first edge publishes nothing", valid_seen, 0);
    pulse_chk(41, 20, 10, -1, "R2 R3 period 41");
    check("R6 count equal to limit", int'(alarm), 0);
    pulse_chk(45, 3, 10, -1, "R3 period 41 again");
    pulse_chk(30, 10, 11, -1, "R3 period 45");
    check("R6 count above limit", int'(alarm), 1);
    pulse_chk(30, 2, 7, 8, "R3 period 30 high 10");
    check("R8 clear", int'(alarm), 0);
    limit = 12'd600;
    pulse_chk(2000, 1000, 7, -1, "R9 period 30 high 2");
    check("R8 alarm stays clear", int'(alarm), 0);
    pulse_chk(20000, 3, 499, 17000, "R3 period 2000");
    check("R7 R8 stall alarm survives clear", int'(alarm), 1);
    pulse_chk(41, 5, 4095, -1, "R4 saturated period");
    pulse_chk(41, 5, 10, 30, "R3 after saturation");
    check("R8 clear after stall", int'(alarm), 0);
    check("R5 valid count", valid_seen, 8);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule